// File: doc/BRIEF.md
# Multi-Rate Serial Link Group Port

This block connects one group of eight serial electrical links to the 16-bit slice of a 40 MHz parallel frame that belongs to the group. It works in both directions. Down the links, it takes a 16-bit field in each frame and sends it out as serial bits on the active link positions. Up the links, it samples the serial inputs and rebuilds a 16-bit field for each frame. The block adds nothing to the data stream: no framing, no coding and no word alignment. Every bit has the same fixed latency from its frame field to its serial slot, and from its serial slot back to its field.

The whole design runs on one fast clock at eight ticks per frame. A frame strobe marks the last tick of each frame. Each direction has its own rate code, which selects 2, 4 or 8 bits per link per frame. The 16-bit budget is fixed, so a faster rate uses fewer link positions. In lane mode, the active links are bonded into one lane, and the field's bits are dealt across them round-robin. Rate and lane settings are sampled only at the frame strobe. On the up side, a frame is flagged not valid when it is the first frame after reset or the first frame under a new setting.

Top module: `elink_group_port`

## Requirements
- R1: The rate code sets the bits per link per frame (B), the ticks per bit (P = 8/B) and the active links (N = 16/B), which are always links 0 to N-1. Code 0 gives B=2, P=4, N=8. Code 1 gives B=4, P=2, N=4. Code 2 gives B=8, P=1, N=2. Code 3 behaves exactly like code 0.
- R2: `frm_stb` is high for one tick in every eight. The down field and both configurations are sampled in that tick, and the next tick is frame phase 0.
- R3: With the down lane flag clear, down link k in bit slot s (s = 0..B-1) carries `dn_field[15-(k*B+s)]`. The bit for frame phase p is driven on `dn_dout` in the tick after phase p. Each slot lasts P ticks and covers phases s*P to s*P+P-1.
- R4: With the down lane flag set, down link k in bit slot s carries `dn_field[15-(s*N+k)]`, which deals the bits round-robin over the bonded links, MSB first.
- R5: Links at index N and above hold `dn_dout` and `dn_lclk` low. Every link holds both outputs low from reset until the first frame has been loaded.
- R6: The forwarded clock `dn_lclk` is aligned with `dn_dout`. For P>=2 it is low in the first half of each bit and high in the second half, so the data changes on its falling edge and is sampled on its rising edge. For P=1 it toggles every bit: low in even slots, high in odd slots.
- R7: Changes to `dn_field`, `dn_rate` or `dn_lane` outside the strobe tick have no effect on the down outputs.
- R8: Up link k is sampled in the last tick of each bit slot, at phase s*P+P-1. It is placed into the up field with the same bit mapping as R3, or as R4 when `up_lane` is set, using the up rate.
- R9: `up_field` for a frame is updated at the strobe that ends that frame, and then holds until the next strobe.
- R10: `up_valid` updates together with `up_field`. It is 0 for the first frame after reset. It is 0 for a frame whose up setting (rate code and lane flag) differs from the previous frame's setting. It is 1 otherwise. It is 0 until the first update.
- R11: Changes to `up_rate` or `up_lane` outside the strobe tick have no effect on the up outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, eight ticks per frame |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_stb | input | 1 | Frame strobe, high in the last tick of each frame |
| dn_field | input | 16 | Down parallel field, sampled at the strobe |
| dn_rate | input | 2 | Down rate code |
| dn_lane | input | 1 | Down lane-bonding enable |
| dn_dout | output | 8 | Serial data to the links |
| dn_lclk | output | 8 | Forwarded clock for each link |
| up_din | input | 8 | Serial data from the links |
| up_rate | input | 2 | Up rate code |
| up_lane | input | 1 | Up lane-bonding enable |
| up_field | output | 16 | Rebuilt up parallel field |
| up_valid | output | 1 | Up field is from a complete, settled frame |

## Verification
The assertions assume that, after its first pulse, the frame strobe comes exactly every eight ticks, so a strobe always lands on frame phase 7. The stimulus keeps to this: it drives the strobe from a fixed eight-tick schedule after reset. Outside the strobe tick, the stimulus scrambles the fields and settings at random. This shows that only strobe-tick values are used. The settings at each strobe mostly repeat the previous frame's settings. They change now and then, so that valid frames and flagged frames are both seen for every rate, with and without bonding.

// File: rtl/elink_grp_pkg.sv
// Shared constants, configuration type and bit-mapping helpers for the
// serial link group. Assumes a fixed 16-bit budget over eight links and
// eight fast ticks per frame.
package elink_grp_pkg;
    localparam int unsigned LINKS = 8;
    localparam int unsigned FBITS = 16;
    localparam int unsigned TICKS = 8;
    localparam int unsigned PH_W  = $clog2(TICKS);
    localparam int unsigned IDX_W = $clog2(FBITS);
    localparam int unsigned MIN_B = FBITS / LINKS;

    typedef struct packed {
        logic       lane;
        logic [1:0] rate;
    } cfg_t;

    // Bits per link per frame; code 3 falls back to the slowest rate.
    function automatic int unsigned bits_per(input logic [1:0] rate);
        return (rate == 2'd3) ? MIN_B : (MIN_B << rate);
    endfunction

    function automatic int unsigned ticks_per_bit(input logic [1:0] rate);
        return TICKS / bits_per(rate);
    endfunction

    function automatic int unsigned links_used(input logic [1:0] rate);
        return FBITS / bits_per(rate);
    endfunction

    // Field bit carried by link k in slot s; 0 for an inactive link.
    function automatic logic [IDX_W-1:0] field_idx(input cfg_t cfg,
                                                   input int unsigned k,
                                                   input int unsigned s);
        int unsigned b;
        int unsigned n;
        b = bits_per(cfg.rate);
        n = FBITS / b;
        if (k >= n)
            return '0;
        if (cfg.lane)
            return IDX_W'(FBITS - 1 - (s * n + k));
        return IDX_W'(FBITS - 1 - (k * b + s));
    endfunction
endpackage

// File: rtl/elink_frame_timer.sv
// Frame phase counter shared by both directions. Phase returns to 0 in the
// tick after each strobe; "armed" marks that a first strobe has been seen.
// Assumes a strobe period of exactly TICKS once armed.
module elink_frame_timer
    import elink_grp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_stb,
    output logic [PH_W-1:0] phase,
    output logic            armed
);
    // Advance the phase and restart it at every frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            armed <= 1'b0;
        end else begin
            phase <= frm_stb ? '0 : phase + 1'b1;
            if (frm_stb)
                armed <= 1'b1;
        end
    end

    // R2
    stb_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_stb && armed) |-> (phase == PH_W'(TICKS - 1)));
endmodule

// File: rtl/elink_ser.sv
// Down-direction serializer. It holds the field sampled at the strobe and
// drives the selected bit of each active link, plus a forwarded clock, one
// tick after each phase. Assumes the phase comes from elink_frame_timer.
module elink_ser
    import elink_grp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_stb,
    input  logic [PH_W-1:0]  phase,
    input  logic             armed,
    input  logic [FBITS-1:0] fld_in,
    input  cfg_t             cfg_in,
    output logic [LINKS-1:0] dout,
    output logic [LINKS-1:0] lclk
);
    logic [FBITS-1:0] hold;
    cfg_t             cfg_q;
    logic [LINKS-1:0] act_mask;
    logic [LINKS-1:0] dout_nx;
    logic [LINKS-1:0] lclk_nx;
    int unsigned      tpb;
    int unsigned      pos;
    int unsigned      slot;
    logic             lk;

    // Capture the field and the down setting at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= '0;
            cfg_q <= '0;
        end else if (frm_stb) begin
            hold  <= fld_in;
            cfg_q <= cfg_in;
        end
    end

    // Pick each link's bit and clock level for the current phase.
    always_comb begin
        tpb  = ticks_per_bit(cfg_q.rate);
        pos  = 32'(phase) % tpb;
        slot = 32'(phase) / tpb;
        lk   = (tpb == 1) ? ((slot & 1) != 0) : (pos >= tpb / 2);
        for (int k = 0; k < LINKS; k++) begin
            act_mask[k] = (k < links_used(cfg_q.rate));
            dout_nx[k]  = act_mask[k] & hold[field_idx(cfg_q, k, slot)];
            lclk_nx[k]  = act_mask[k] & lk;
        end
    end

    // Register the link outputs, held low until the first frame is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            dout <= '0;
            lclk <= '0;
        end else begin
            dout <= dout_nx;
            lclk <= lclk_nx;
        end
    end

    // R7
    dn_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |=> $stable(cfg_q));

    // R5
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |=> (((dout | lclk) & ~$past(act_mask)) == '0));

    // R3
    bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pos != 0) |=> $stable(dout));
endmodule

// File: rtl/elink_deser.sv
// Up-direction deserializer. It samples each active link in the last tick
// of every bit slot, rebuilds the field and publishes it at the strobe.
// Frames after reset or after a setting change are flagged not valid.
// Assumes strobe timing as checked in elink_frame_timer.
module elink_deser
    import elink_grp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_stb,
    input  logic [PH_W-1:0]  phase,
    input  logic             armed,
    input  logic [LINKS-1:0] din,
    input  cfg_t             cfg_in,
    output logic [FBITS-1:0] fld_out,
    output logic             vld
);
    cfg_t             cfg_q;
    logic             chg;
    logic [FBITS-1:0] acc;
    logic [FBITS-1:0] acc_nx;
    int unsigned      tpb;
    int unsigned      pos;
    int unsigned      slot;

    // Latch the up setting at the boundary and note whether it changed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            chg   <= 1'b1;
        end else if (frm_stb) begin
            cfg_q <= cfg_in;
            chg   <= (cfg_in != cfg_q) || !armed;
        end
    end

    // Merge the bits sampled in this tick into the frame accumulator.
    always_comb begin
        tpb    = ticks_per_bit(cfg_q.rate);
        pos    = 32'(phase) % tpb;
        slot   = 32'(phase) / tpb;
        acc_nx = acc;
        if (pos == tpb - 1) begin
            for (int k = 0; k < LINKS; k++) begin
                if (k < links_used(cfg_q.rate))
                    acc_nx[field_idx(cfg_q, k, slot)] = din[k];
            end
        end
    end

    // Keep the partially assembled frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else
            acc <= acc_nx;
    end

    // Publish the finished frame and its valid flag at the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_out <= '0;
            vld     <= 1'b0;
        end else if (frm_stb && armed) begin
            fld_out <= acc_nx;
            vld     <= !chg;
        end
    end

    // R11
    up_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |=> $stable(cfg_q));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |=> ($stable(fld_out) && $stable(vld)));
endmodule

// File: rtl/elink_group_port.sv
// Top of one eight-link serial group: a shared frame timer, a down-direction
// serializer and an up-direction deserializer, each with its own rate and
// lane setting. Assumes one fast clock at TICKS ticks per frame.
module elink_group_port
    import elink_grp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frm_stb,
    input  logic [15:0] dn_field,
    input  logic [1:0]  dn_rate,
    input  logic        dn_lane,
    output logic [7:0]  dn_dout,
    output logic [7:0]  dn_lclk,
    input  logic [7:0]  up_din,
    input  logic [1:0]  up_rate,
    input  logic        up_lane,
    output logic [15:0] up_field,
    output logic        up_valid
);
    logic [PH_W-1:0] phase;
    logic            armed;
    cfg_t            dn_cfg;
    cfg_t            up_cfg;

    assign dn_cfg = '{lane: dn_lane, rate: dn_rate};
    assign up_cfg = '{lane: up_lane, rate: up_rate};

    elink_frame_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .frm_stb (frm_stb),
        .phase   (phase),
        .armed   (armed)
    );

    elink_ser u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .frm_stb (frm_stb),
        .phase   (phase),
        .armed   (armed),
        .fld_in  (dn_field),
        .cfg_in  (dn_cfg),
        .dout    (dn_dout),
        .lclk    (dn_lclk)
    );

    elink_deser u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .frm_stb (frm_stb),
        .phase   (phase),
        .armed   (armed),
        .din     (up_din),
        .cfg_in  (up_cfg),
        .fld_out (up_field),
        .vld     (up_valid)
    );
endmodule

// File: tb/elink_group_port_tb.sv
// Self-checking bench: per-frame settings and fields (directed first, then
// seeded random), scrambled inputs between strobes, reference model in
// bench functions.
module elink_group_port_tb;
    localparam int NF = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_stb = 1'b0;
    logic [15:0] dn_field = '0;
    logic [1:0]  dn_rate = '0;
    logic        dn_lane = 1'b0;
    logic [7:0]  dn_dout;
    logic [7:0]  dn_lclk;
    logic [7:0]  up_din = '0;
    logic [1:0]  up_rate = '0;
    logic        up_lane = 1'b0;
    logic [15:0] up_field;
    logic        up_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] fld_h [NF];
    logic [1:0]  tr_h  [NF];
    logic        tl_h  [NF];
    logic [1:0]  rr_h  [NF];
    logic        rl_h  [NF];
    logic [7:0]  din_h [NF*8];

    always #5 clk = ~clk;

    elink_group_port u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_stb  (frm_stb),
        .dn_field (dn_field),
        .dn_rate  (dn_rate),
        .dn_lane  (dn_lane),
        .dn_dout  (dn_dout),
        .dn_lclk  (dn_lclk),
        .up_din   (up_din),
        .up_rate  (up_rate),
        .up_lane  (up_lane),
        .up_field (up_field),
        .up_valid (up_valid)
    );

    function automatic int bpl(input logic [1:0] r);
        case (r)
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 2;
        endcase
    endfunction

    function automatic int bit_of(input logic [1:0] r, input logic ln,
                                  input int k, input int s);
        int b;
        int n;
        b = bpl(r);
        n = 16 / b;
        return ln ? 15 - (s * n + k) : 15 - (k * b + s);
    endfunction

    // Expected {lclk, dout} for a frame field at a given phase.
    function automatic logic [15:0] tx_exp(input logic [15:0] fld, input logic [1:0] r,
                                           input logic ln, input int ph);
        int b;
        int p;
        int s;
        logic lk;
        logic [7:0] d;
        logic [7:0] c;
        b  = bpl(r);
        p  = 8 / b;
        s  = ph / p;
        lk = (p == 1) ? ((s % 2) == 1) : ((ph % p) >= p / 2);
        d  = '0;
        c  = '0;
        for (int k = 0; k < 16 / b; k++) begin
            d[k] = fld[bit_of(r, ln, k, s)];
            c[k] = lk;
        end
        return {c, d};
    endfunction

    // Expected up field for frame f from the recorded link inputs.
    function automatic logic [15:0] rx_exp(input int f);
        int b;
        int p;
        logic [15:0] v;
        b = bpl(rr_h[f]);
        p = 8 / b;
        v = '0;
        for (int k = 0; k < 16 / b; k++)
            for (int s = 0; s < b; s++)
                v[bit_of(rr_h[f], rl_h[f], k, s)] = din_h[8*f + s*p + p - 1][k];
        return v;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250));
        // Directed corner frames, then mostly-repeating random settings.
        fld_h[0] = '0; tr_h[0] = '0; tl_h[0] = 1'b0; rr_h[0] = '0; rl_h[0] = 1'b0;
        fld_h[1] = 16'hA5C3; tr_h[1] = 2'd0; tl_h[1] = 1'b0;
        fld_h[2] = 16'h8001; tr_h[2] = 2'd0; tl_h[2] = 1'b1;
        fld_h[3] = 16'hFFFF; tr_h[3] = 2'd1; tl_h[3] = 1'b0;
        fld_h[4] = 16'h1234; tr_h[4] = 2'd1; tl_h[4] = 1'b1;
        fld_h[5] = 16'hF00F; tr_h[5] = 2'd2; tl_h[5] = 1'b0;
        fld_h[6] = 16'h0001; tr_h[6] = 2'd2; tl_h[6] = 1'b1;
        fld_h[7] = 16'h7E81; tr_h[7] = 2'd3; tl_h[7] = 1'b0;
        fld_h[8] = 16'h0000; tr_h[8] = 2'd3; tl_h[8] = 1'b0;
        for (int f = 1; f <= 8; f++) begin
            rr_h[f] = tr_h[f];
            rl_h[f] = tl_h[f];
        end
        for (int f = 9; f < NF; f++) begin
            fld_h[f] = 16'($urandom);
            if (($urandom % 4) == 0) begin
                tr_h[f] = 2'($urandom);
                tl_h[f] = 1'($urandom);
            end else begin
                tr_h[f] = tr_h[f-1];
                tl_h[f] = tl_h[f-1];
            end
            if (($urandom % 4) == 0) begin
                rr_h[f] = 2'($urandom);
                rl_h[f] = 1'($urandom);
            end else begin
                rr_h[f] = rr_h[f-1];
                rl_h[f] = rl_h[f-1];
            end
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int g = 0; g < NF * 8; g++) begin
            // Sample outputs that reflect the edge ending cycle g-1.
            if (g == 0) begin
                check("R5 reset dn_dout/dn_lclk", {dn_lclk, dn_dout}, 16'h0000);
                check("R10 R9 reset up_valid/up_field", {15'd0, up_valid}, 16'h0000);
            end else begin
                int q;
                int f;
                logic [15:0] e;
                q = g - 1;
                f = q / 8;
                e = (f == 0) ? 16'h0000 : tx_exp(fld_h[f], tr_h[f], tl_h[f], q % 8);
                if (tl_h[f])
                    check("R4 R1 R2 R5 R7 lane dn_dout", {8'd0, dn_dout}, {8'd0, e[7:0]});
                else
                    check("R3 R1 R2 R5 R7 dn_dout", {8'd0, dn_dout}, {8'd0, e[7:0]});
                check("R6 R5 dn_lclk", {8'd0, dn_lclk}, {8'd0, e[15:8]});
            end
            if (g % 8 == 0 && g > 0) begin
                int f;
                logic ev;
                f = g / 8 - 1;
                if (f == 0) begin
                    check("R9 R10 before first frame", {up_field[14:0], up_valid}, 16'h0000);
                end else begin
                    ev = (f >= 2) && (rr_h[f] == rr_h[f-1]) && (rl_h[f] == rl_h[f-1]);
                    check("R8 R9 R11 up_field", up_field, rx_exp(f));
                    check("R10 up_valid", {15'd0, up_valid}, {15'd0, ev});
                end
            end
            // Drive inputs for cycle g.
            frm_stb = (g % 8 == 7);
            up_din  = 8'($urandom);
            din_h[g] = up_din;
            if (frm_stb && (g / 8 + 1) < NF) begin
                dn_field = fld_h[g/8+1];
                dn_rate  = tr_h[g/8+1];
                dn_lane  = tl_h[g/8+1];
                up_rate  = rr_h[g/8+1];
                up_lane  = rl_h[g/8+1];
            end else begin
                dn_field = 16'($urandom);
                dn_rate  = 2'($urandom);
                dn_lane  = 1'($urandom);
                up_rate  = 2'($urandom);
                up_lane  = 1'($urandom);
            end
            @(negedge clk);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule